// File: doc/BRIEF.md
# Sixteen-Entry Register Bank with Constant Generator

This block holds the architectural registers of a small 16-bit RISC core. Entry 0 is the program counter, entry 1 the stack pointer and entry 2 the status word. Entry 3 stores nothing and exists only as a constant source. All other entries are general purpose. The bank has three ports. A source read port takes a register number together with a 2-bit source addressing-mode code. A destination read port takes a register number only. A single write port accepts either a full word or a byte.

When the source port selects entry 2 or entry 3, the mode code can turn the read into a hardwired constant: 0, 1, 2, 4, 8 or all ones. The operand is then ready in the same cycle, with no extra instruction word and no memory access. This lets a core emulate increment, decrement, clear and bit operations with ordinary two-operand instructions. One mode code on entry 2 means absolute addressing. For that code the port returns a zero base and raises a flag, which tells the operand-fetch stage to take the address from an extension word.

The program counter and the stack pointer each have a dedicated step path. These paths run alongside the write port, and the write port wins when both target the same register. All reads are combinational and see the register contents from before the current clock edge. The block has no streaming data path, so every pin is a plain control or data signal with no handshake.

Top module: `regbank_cg`

## Requirements
- R1: While `rst_n` is low, every entry is cleared, except that the program counter loads `rst_vector` with bit 0 forced to 0.
- R2: For source entries other than 2 and 3, `src_data` returns the stored contents whatever the mode code. For entry 2 with mode `2'b00`, `src_data` returns the stored status word.
- R3: For source entry 2, mode `2'b01` returns 16'h0000, mode `2'b10` returns 16'h0004 and mode `2'b11` returns 16'h0008.
- R4: For source entry 3, modes `2'b00`, `2'b01`, `2'b10` and `2'b11` return 16'h0000, 16'h0001, 16'h0002 and 16'hFFFF respectively.
- R5: `src_abs` is 1 exactly when the source entry is 2 and the mode is `2'b01`.
- R6: A word write (`wr_en`=1, `wr_byte`=0) to an entry other than 3 stores all 16 bits. From the next cycle the value is visible on both read ports.
- R7: A byte write (`wr_byte`=1) stores `wr_data[7:0]` and clears bits 15:8 of the target entry.
- R8: Writes to entry 3 leave no trace, and `dst_data` reads 16'h0000 when `dst_sel` is 3.
- R9: Bit 0 of the program counter is 0 after every write to entry 0.
- R10: With `pc_inc`=1, the program counter advances by 2 at the clock edge. A write to entry 0 in the same cycle takes precedence over the increment.
- R11: With `sp_step`=1, the stack pointer moves by 2, downward when `sp_down`=1 and upward otherwise. A write to entry 1 in the same cycle takes precedence over the step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rst_vector | input | 16 | Program counter value loaded at reset |
| src_sel | input | 4 | Source entry number |
| src_mode | input | 2 | Source addressing-mode code |
| src_data | output | 16 | Source operand: register contents or constant |
| src_abs | output | 1 | Absolute-address extension word required |
| dst_sel | input | 4 | Destination read entry number |
| dst_data | output | 16 | Destination read data |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 4 | Write target entry |
| wr_byte | input | 1 | 1 = byte write, 0 = word write |
| wr_data | input | 16 | Write data |
| pc_inc | input | 1 | Advance program counter by 2 |
| sp_step | input | 1 | Move stack pointer by 2 |
| sp_down | input | 1 | Step direction: 1 = down, 0 = up |
| pc_o | output | 16 | Current program counter |
| sp_o | output | 16 | Current stack pointer |

## Verification
The bound checker enforces the following on every cycle:
- the constant values for entry 2 and entry 3;
- the zero base whenever the absolute flag is up;
- the zero read of entry 3 on the destination port;
- that the program counter stays even;
- the step behaviour of the program counter and stack pointer when no write competes;
- the cleared high byte after a byte write to the stack pointer.

Other behaviours can only be shown by the bench's scenarios, where a reference model tracks every entry:
- data written to a general entry and read back later;
- byte writes landing in arbitrary entries;
- a write taking precedence over a step in the same cycle;
- a write to entry 3 leaving no trace.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  // Source addressing-mode codes as seen on src_mode
  typedef enum logic [1:0] {
    AM_DIRECT  = 2'b00,
    AM_OFFSET  = 2'b01,
    AM_POINTER = 2'b10,
    AM_POSTINC = 2'b11
  } src_mode_e;

  // Entries with a fixed role
  localparam int unsigned IDX_PC = 0;
  localparam int unsigned IDX_SP = 1;
  localparam int unsigned IDX_SR = 2;
  localparam int unsigned IDX_CG = 3;
endpackage

// File: rtl/regbank_store.sv
module regbank_store
  import regbank_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 16,
  parameter int unsigned BW   = 8,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     rst_vector,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_sel,
  input  logic              wr_byte,
  input  logic [DW-1:0]     wr_data,
  input  logic              pc_inc,
  input  logic              sp_step,
  input  logic              sp_down,
  output logic [NREG*DW-1:0] regs_flat
);
  localparam logic [DW-1:0] STEP = DW'(2);
  localparam logic [DW-1:0] EVEN = ~DW'(1);

  // Byte writes keep the low lane and zero the rest
  logic [DW-1:0] wr_fmt;
  assign wr_fmt = wr_byte ? {{(DW-BW){1'b0}}, wr_data[BW-1:0]} : wr_data;

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    if (i == IDX_CG) begin : g_hole
      assign regs_flat[i*DW +: DW] = '0;
    end else begin : g_reg
      logic [DW-1:0] q, d, rst_val;
      logic          hit;
      assign hit = wr_en && (wr_sel == AW'(i));
      if (i == IDX_PC) begin : g_pc
        assign rst_val = rst_vector & EVEN;
        always_comb begin
          d = q;
          if (hit)         d = wr_fmt & EVEN;
          else if (pc_inc) d = q + STEP;
        end
      end else if (i == IDX_SP) begin : g_sp
        assign rst_val = '0;
        always_comb begin
          d = q;
          if (hit)          d = wr_fmt;
          else if (sp_step) d = sp_down ? q - STEP : q + STEP;
        end
      end else begin : g_gp
        assign rst_val = '0;
        assign d = hit ? wr_fmt : q;
      end
      always_ff @(posedge clk) begin
        if (!rst_n) q <= rst_val;
        else        q <= d;
      end
      assign regs_flat[i*DW +: DW] = q;
    end
  end
endmodule

// File: rtl/regbank_srcport.sv
module regbank_srcport
  import regbank_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 16,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic [NREG*DW-1:0] regs_flat,
  input  logic [AW-1:0]      src_sel,
  input  logic [1:0]         src_mode,
  output logic [DW-1:0]      src_data,
  output logic               src_abs
);
  logic [DW-1:0] raw;
  src_mode_e     mode;
  assign raw  = regs_flat[src_sel*DW +: DW];
  assign mode = src_mode_e'(src_mode);

  always_comb begin
    src_data = raw;
    src_abs  = 1'b0;
    if (src_sel == AW'(IDX_SR)) begin
      unique case (mode)
        AM_DIRECT:  src_data = raw;
        AM_OFFSET:  begin src_data = '0; src_abs = 1'b1; end
        AM_POINTER: src_data = DW'(4);
        AM_POSTINC: src_data = DW'(8);
        default:    src_data = raw;
      endcase
    end else if (src_sel == AW'(IDX_CG)) begin
      unique case (mode)
        AM_DIRECT:  src_data = '0;
        AM_OFFSET:  src_data = DW'(1);
        AM_POINTER: src_data = DW'(2);
        AM_POSTINC: src_data = '1;
        default:    src_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/regbank_cg.sv
module regbank_cg
  import regbank_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 16,
  parameter int unsigned BW   = 8,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rst_vector,
  input  logic [AW-1:0] src_sel,
  input  logic [1:0]    src_mode,
  output logic [DW-1:0] src_data,
  output logic          src_abs,
  input  logic [AW-1:0] dst_sel,
  output logic [DW-1:0] dst_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_sel,
  input  logic          wr_byte,
  input  logic [DW-1:0] wr_data,
  input  logic          pc_inc,
  input  logic          sp_step,
  input  logic          sp_down,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] sp_o
);
  logic [NREG*DW-1:0] regs_flat;

  regbank_store #(.DW(DW), .NREG(NREG), .BW(BW)) u_store (
    .clk(clk), .rst_n(rst_n), .rst_vector(rst_vector),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte), .wr_data(wr_data),
    .pc_inc(pc_inc), .sp_step(sp_step), .sp_down(sp_down),
    .regs_flat(regs_flat)
  );

  regbank_srcport #(.DW(DW), .NREG(NREG)) u_src (
    .regs_flat(regs_flat), .src_sel(src_sel), .src_mode(src_mode),
    .src_data(src_data), .src_abs(src_abs)
  );

  assign dst_data = regs_flat[dst_sel*DW +: DW];
  assign pc_o     = regs_flat[IDX_PC*DW +: DW];
  assign sp_o     = regs_flat[IDX_SP*DW +: DW];
endmodule

// File: rtl/regbank_cg_chk.sv
module regbank_cg_chk #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 16,
  parameter int unsigned BW   = 8,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] rst_vector,
  input logic [AW-1:0] src_sel,
  input logic [1:0]    src_mode,
  input logic [DW-1:0] src_data,
  input logic          src_abs,
  input logic [AW-1:0] dst_sel,
  input logic [DW-1:0] dst_data,
  input logic          wr_en,
  input logic [AW-1:0] wr_sel,
  input logic          wr_byte,
  input logic [DW-1:0] wr_data,
  input logic          pc_inc,
  input logic          sp_step,
  input logic          sp_down,
  input logic [DW-1:0] pc_o,
  input logic [DW-1:0] sp_o
);
  assert_sr_four_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == AW'(2) && src_mode == 2'b10) |-> src_data == DW'(4));
  assert_sr_eight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == AW'(2) && src_mode == 2'b11) |-> src_data == DW'(8));
  assert_cg_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == AW'(3) && src_mode == 2'b11) |-> src_data == '1);
  assert_cg_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == AW'(3) && src_mode == 2'b01) |-> src_data == DW'(1));
  assert_abs_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    src_abs |-> src_data == '0);
  assert_cg_dst_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dst_sel == AW'(3) |-> dst_data == '0);
  assert_pc_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_o[0] == 1'b0);
  assert_pc_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_inc && !(wr_en && wr_sel == AW'(0))) |=> pc_o == $past(pc_o) + DW'(2));
  assert_sp_down_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_step && sp_down && !(wr_en && wr_sel == AW'(1))) |=> sp_o == $past(sp_o) - DW'(2));
  assert_sp_up_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_step && !sp_down && !(wr_en && wr_sel == AW'(1))) |=> sp_o == $past(sp_o) + DW'(2));
  assert_sp_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_byte && wr_sel == AW'(1)) |=> sp_o[DW-1:BW] == '0);
endmodule

bind regbank_cg regbank_cg_chk #(.DW(DW), .NREG(NREG), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_vector(rst_vector),
  .src_sel(src_sel), .src_mode(src_mode), .src_data(src_data), .src_abs(src_abs),
  .dst_sel(dst_sel), .dst_data(dst_data),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte), .wr_data(wr_data),
  .pc_inc(pc_inc), .sp_step(sp_step), .sp_down(sp_down),
  .pc_o(pc_o), .sp_o(sp_o)
);

// File: tb/test_regbank_cg.sv
module test_regbank_cg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rst_vector = 16'hC001;
  logic [3:0]  src_sel = '0, dst_sel = '0, wr_sel = '0;
  logic [1:0]  src_mode = '0;
  logic        wr_en = 1'b0, wr_byte = 1'b0, pc_inc = 1'b0, sp_step = 1'b0, sp_down = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] src_data, dst_data, pc_o, sp_o;
  logic        src_abs;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] model [16];

  always #4 clk = ~clk;

  regbank_cg i_regbank_cg (
    .clk(clk), .rst_n(rst_n), .rst_vector(rst_vector),
    .src_sel(src_sel), .src_mode(src_mode), .src_data(src_data), .src_abs(src_abs),
    .dst_sel(dst_sel), .dst_data(dst_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte), .wr_data(wr_data),
    .pc_inc(pc_inc), .sp_step(sp_step), .sp_down(sp_down),
    .pc_o(pc_o), .sp_o(sp_o)
  );

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_src(logic [3:0] s, logic [1:0] m);
    logic [15:0] r3c [4];
    logic [15:0] r2c [4];
    r3c = '{16'h0000, 16'h0001, 16'h0002, 16'hFFFF};
    r2c = '{model[2], 16'h0000, 16'h0004, 16'h0008};
    if (s == 4'd2) return r2c[m];
    if (s == 4'd3) return r3c[m];
    return model[s];
  endfunction

  // Compare all outputs against the model, 1 time unit after the inputs change
  task automatic compare_all();
    string st;
    #1;
    st = (src_sel == 4'd3) ? "R4" : ((src_sel == 4'd2 && src_mode != 2'b00) ? "R3" : "R2");
    chk(st, "src_data", src_data, exp_src(src_sel, src_mode));
    chk("R5", "src_abs", {15'd0, src_abs}, {15'd0, (src_sel == 4'd2 && src_mode == 2'b01)});
    chk(dst_sel == 4'd3 ? "R8" : "R6", "dst_data", dst_data, (dst_sel == 4'd3) ? 16'h0 : model[dst_sel]);
    chk("R10", "pc_o", pc_o, model[0]);
    chk("R11", "sp_o", sp_o, model[1]);
  endtask

  task automatic drive(logic [3:0] ss, logic [1:0] sm, logic [3:0] ds,
                       logic we, logic [3:0] ws, logic wb, logic [15:0] wd,
                       logic pi, logic spst, logic spd);
    @(negedge clk);
    src_sel = ss; src_mode = sm; dst_sel = ds;
    wr_en = we; wr_sel = ws; wr_byte = wb; wr_data = wd;
    pc_inc = pi; sp_step = spst; sp_down = spd;
    compare_all();
  endtask

  // Advance the model across the next rising edge using the driven inputs
  task automatic tick();
    logic [15:0] v;
    logic pc_w, sp_w;
    @(posedge clk);
    pc_w = wr_en && wr_sel == 4'd0;
    sp_w = wr_en && wr_sel == 4'd1;
    if (pc_inc && !pc_w) model[0] = model[0] + 16'd2;
    if (sp_step && !sp_w) model[1] = sp_down ? model[1] - 16'd2 : model[1] + 16'd2;
    if (wr_en && wr_sel != 4'd3) begin
      v = wr_byte ? {8'h00, wr_data[7:0]} : wr_data;
      if (wr_sel == 4'd0) v[0] = 1'b0;
      model[wr_sel] = v;
    end
  endtask

  initial begin : watchdog
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < 16; i++) model[i] = 16'h0;
    model[0] = 16'hC000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen at the ports
    #1;
    chk("R1", "pc after reset", pc_o, 16'hC000);
    chk("R1", "sp after reset", sp_o, 16'h0000);
    for (int i = 2; i < 16; i++) begin
      dst_sel = 4'(i);
      #1;
      chk("R1", "entry after reset", dst_data, 16'h0000);
    end

    // R6: word write then read back on both ports
    drive(4'd7, 2'b00, 4'd7, 1'b1, 4'd7, 1'b0, 16'hA5C3, 1'b0, 1'b0, 1'b0); tick();
    drive(4'd7, 2'b11, 4'd7, 1'b0, 4'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
    chk("R6", "word readback", dst_data, 16'hA5C3);
    tick();
    // R7: byte write clears upper lane
    drive(4'd0, 2'b00, 4'd0, 1'b1, 4'd9, 1'b1, 16'h1234, 1'b0, 1'b0, 1'b0); tick();
    drive(4'd9, 2'b00, 4'd9, 1'b0, 4'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
    chk("R7", "byte write", dst_data, 16'h0034);
    tick();
    // R9: odd value written to PC lands even; R10: write beats increment
    drive(4'd0, 2'b00, 4'd0, 1'b1, 4'd0, 1'b0, 16'h4567, 1'b1, 1'b0, 1'b0); tick();
    drive(4'd0, 2'b00, 4'd0, 1'b0, 4'd0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0);
    chk("R9", "pc forced even", pc_o, 16'h4566);
    tick();
    drive(4'd0, 2'b00, 4'd0, 1'b0, 4'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
    chk("R10", "pc incremented", pc_o, 16'h4568);
    tick();
    // R11: write beats step, then step down
    drive(4'd1, 2'b00, 4'd1, 1'b1, 4'd1, 1'b0, 16'h0400, 1'b0, 1'b1, 1'b1); tick();
    drive(4'd1, 2'b00, 4'd1, 1'b0, 4'd0, 1'b0, 16'h0, 1'b0, 1'b1, 1'b1); tick();
    drive(4'd1, 2'b00, 4'd1, 1'b0, 4'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
    chk("R11", "sp write then down step", sp_o, 16'h03FE);
    tick();
    // R8: write to entry 3 leaves nothing behind
    drive(4'd3, 2'b00, 4'd3, 1'b1, 4'd3, 1'b0, 16'hBEEF, 1'b0, 1'b0, 1'b0); tick();
    drive(4'd3, 2'b00, 4'd3, 1'b0, 4'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
    chk("R8", "entry 3 after write", dst_data, 16'h0000);
    tick();
    // R2/R3/R4/R5: all constant-generator codes with a nonzero status word
    drive(4'd0, 2'b00, 4'd0, 1'b1, 4'd2, 1'b0, 16'h0107, 1'b0, 1'b0, 1'b0); tick();
    for (int m = 0; m < 4; m++) begin
      drive(4'd2, 2'(m), 4'd2, 1'b0, 4'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0); tick();
      drive(4'd3, 2'(m), 4'd2, 1'b0, 4'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0); tick();
      drive(4'd5, 2'(m), 4'd2, 1'b0, 4'd0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0); tick();
    end

    // Random traffic compared every cycle against the model
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] ss;
      ss = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(2, 3)) : 4'($urandom);
      drive(ss, 2'($urandom), 4'($urandom),
            1'($urandom_range(0, 1)), 4'($urandom), 1'($urandom_range(0, 3) == 0),
            16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      tick();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule